// File: doc/BRIEF.md
# Flash Program/Erase Sequencing Controller

This block governs every change made to a modelled on-chip nonvolatile program store of 24-bit instruction words. Software prepares an operation through a small register interface: a control register that selects the operation and carries the write-enable, start, busy and error bits; a write-only key register; and a target address register. A holding buffer of one row (64 words) is filled one word at a time by table-write accesses. The buffer is the only thing these accesses touch.

Three operations exist: erase of an aligned page of eight rows, programming of a whole row from the holding buffer, and programming of one word. Each one must be armed by a fresh two-byte unlock sequence on the key register, written just before the start bit is set. While an operation runs, the block raises a stall output for a fixed number of cycles, set per operation. Programming can only clear bits. Only an erase returns words to all ones.

The array is a behavioural register store inside the block, reset to the erased state. It can be observed through a combinational read port.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the control readback is 0x0000, stall is low and every array word reads 24'hFFFFFF.
- R2: An operation is armed only by a key write of 0x0055 followed by a key write of 0x00AA, with no other register write between them. A wrong key value, a reversed order or an intervening control or target write leaves the block unarmed. In that case a start write (bit 15) performs nothing, keeps stall low and sets the error bit (bit 13). Any control write without bit 15 clears the error bit.
- R3: A start write whose write-enable bit (bit 14) is 0 is refused: no stall, error bit set, array unchanged.
- R4: An accepted start raises stall in the next cycle and shows busy in bit 15 of the readback. Both drop by themselves after exactly 11064 cycles for a row program, ERASE_CYCLES (16000) for a page erase and WORD_CYCLES (2000) for a word program.
- R5: Every start attempt consumes the armed state, so a second start without a new unlock is refused with the error bit.
- R6: Operation code 2'b01 in bits 1:0 erases the 512-word page that contains the target address, setting every word to 24'hFFFFFF. The low 9 address bits are ignored and other pages are unchanged.
- R7: Operation code 2'b10 programs the 64-word row whose buffer was loaded. The buffer must first be loaded with 64 table writes at offsets 0 to 63 in order, all inside one 64-aligned group. After the row program the buffer is empty, and a further row start is refused.
- R8: A load sequence that skips an offset, or that leaves its aligned group, makes a row start fail with the error bit and no array change.
- R9: Operation code 2'b11 programs one word: the data of the latest table write, at the latest target (table-write address or target register write).
- R10: Programming stores the AND of the old word and the new data, so it never sets a bit.
- R11: Table writes change only the holding buffer, never the array.
- R12: While stall is high, register writes, key writes and table writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 key, 2 target address |
| bus_wdata | input | 16 | Register write data |
| ctrl_rdata | output | 16 | Control readback {busy, wren, err, 11'b0, op} |
| tbl_wr | input | 1 | Table-write strobe into the holding buffer |
| tbl_addr | input | ADDR_W (10) | Word address of the table write |
| tbl_wdata | input | 24 | Instruction word of the table write |
| stall | output | 1 | High while an operation runs |
| rd_addr | input | ADDR_W (10) | Array observation address |
| rd_data | output | 24 | Array word at rd_addr |

## Verification
Word programs are applied twice to the same address, with overlapping bit patterns. The second result can only match a bit-clearing AND, not an overwrite. Row programs use a full in-order load of distinct per-offset data, which separates correct row placement and offset mapping from shifted or mis-grouped writes. They also use a load with a skipped offset and a load that strays into the next group, which separate sequence tracking from simple counting. Unlock patterns include a correct pair, a pair broken by a control write, a wrong middle key and a reversed pair, so a key check that ignores order or adjacency is exposed. A page erase aimed at a mid-page address shows whether the page bits alone select the target.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_ROW   = 2'd2,
    OP_WORD  = 2'd3
  } fsc_op_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_TGT  = 2'd2,
    SEL_RSVD = 2'd3
  } fsc_sel_e;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;

  localparam int CTL_START = 15;
  localparam int CTL_WREN  = 14;
  localparam int CTL_ERR   = 13;
endpackage

// File: rtl/fsc_keyguard.sv
module fsc_keyguard
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_data,
  input  logic        other_wr,
  output logic        armed
);
  typedef enum logic [1:0] {KG_IDLE, KG_HALF, KG_ARMED} kg_e;

  kg_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      if (key_data == KEY_FIRST) begin
        state_d = KG_HALF;
      end else if (key_data == KEY_SECOND && state_q == KG_HALF) begin
        state_d = KG_ARMED;
      end else begin
        state_d = KG_IDLE;
      end
    end else if (other_wr) begin
      state_d = KG_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KG_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KG_ARMED);
endmodule

// File: rtl/fsc_timer.sv
module fsc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = load;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fsc_rowbuf.sv
module fsc_rowbuf #(
  parameter int WORD_W    = 24,
  parameter int ROW_WORDS = 64,
  parameter int ADDR_W    = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_en,
  input  logic [ADDR_W-1:0]               ld_addr,
  input  logic [WORD_W-1:0]               ld_data,
  input  logic                            clr,
  output logic                            full_ok,
  output logic [ADDR_W-$clog2(ROW_WORDS)-1:0] group_row,
  output logic [WORD_W-1:0]               slots [ROW_WORDS]
);
  localparam int OFS_W = $clog2(ROW_WORDS);
  localparam int ROW_W = ADDR_W - OFS_W;
  localparam logic [OFS_W:0] CNT_FULL = (OFS_W+1)'(ROW_WORDS);

  logic [OFS_W:0]  cnt_q, cnt_d;
  logic            bad_q, bad_d;
  logic [ROW_W-1:0] group_q, group_d;
  logic [OFS_W-1:0] ofs;
  logic [ROW_W-1:0] row;
  logic            in_seq;
  logic            slot_we;

  assign ofs = ld_addr[OFS_W-1:0];
  assign row = ld_addr[ADDR_W-1:OFS_W];

  assign in_seq = !bad_q && (cnt_q != '0) && (cnt_q < CNT_FULL) &&
                  ({1'b0, ofs} == cnt_q) && (row == group_q);

  always_comb begin
    cnt_d   = cnt_q;
    bad_d   = bad_q;
    group_d = group_q;
    slot_we = 1'b0;
    if (clr) begin
      cnt_d = '0;
      bad_d = 1'b0;
    end else if (ld_en) begin
      if (ofs == '0) begin
        cnt_d   = (OFS_W+1)'(1);
        bad_d   = 1'b0;
        group_d = row;
        slot_we = 1'b1;
      end else if (in_seq) begin
        cnt_d   = cnt_q + 1'b1;
        slot_we = 1'b1;
      end else begin
        bad_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bad_q   <= 1'b0;
      group_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      bad_q   <= bad_d;
      group_q <= group_d;
    end
  end

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (slot_we && ofs == OFS_W'(g)) slot_q <= ld_data;
    end
    assign slots[g] = slot_q;
  end

  assign full_ok   = (cnt_q == CNT_FULL) && !bad_q;
  assign group_row = group_q;
endmodule

// File: rtl/fsc_array.sv
module fsc_array
  import fsc_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int ROW_WORDS  = 64,
  parameter int PAGE_WORDS = 512,
  parameter int NUM_WORDS  = 1024,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  fsc_op_e           upd_op,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [WORD_W-1:0] word_data,
  input  logic [WORD_W-1:0] row_data [ROW_WORDS],
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int OFS_W    = $clog2(ROW_WORDS);
  localparam int PG_OFS_W = $clog2(PAGE_WORDS);

  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
    logic [WORD_W-1:0] word_q, word_d;
    logic              hit;

    always_comb begin
      hit    = 1'b0;
      word_d = word_q;
      case (upd_op)
        OP_ERASE: begin
          hit    = (WADDR[ADDR_W-1:PG_OFS_W] == upd_addr[ADDR_W-1:PG_OFS_W]);
          word_d = '1;
        end
        OP_ROW: begin
          hit    = (WADDR[ADDR_W-1:OFS_W] == upd_addr[ADDR_W-1:OFS_W]);
          word_d = word_q & row_data[w % ROW_WORDS];
        end
        OP_WORD: begin
          hit    = (WADDR == upd_addr);
          word_d = word_q & word_data;
        end
        default: begin
          hit    = 1'b0;
          word_d = word_q;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             word_q <= '1;
      else if (upd_en && hit) word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fsc_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int ROW_WORDS    = 64,
  parameter int PAGE_ROWS    = 8,
  parameter int NUM_PAGES    = 2,
  parameter int ROW_CYCLES   = 11064,
  parameter int ERASE_CYCLES = 16000,
  parameter int WORD_CYCLES  = 2000,
  localparam int PAGE_WORDS  = ROW_WORDS * PAGE_ROWS,
  localparam int NUM_WORDS   = PAGE_WORDS * NUM_PAGES,
  localparam int ADDR_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       ctrl_rdata,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [WORD_W-1:0] tbl_wdata,
  output logic              stall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int OFS_W   = $clog2(ROW_WORDS);
  localparam int ROW_W   = ADDR_W - OFS_W;
  localparam int MAX_CYC = (ROW_CYCLES > ERASE_CYCLES) ?
                           ((ROW_CYCLES > WORD_CYCLES) ? ROW_CYCLES : WORD_CYCLES) :
                           ((ERASE_CYCLES > WORD_CYCLES) ? ERASE_CYCLES : WORD_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // control and target state
  logic              wren_q, wren_d;
  logic              err_q, err_d;
  fsc_op_e           op_q, op_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  fsc_op_e           run_op_q, run_op_d;
  logic [ADDR_W-1:0] run_addr_q, run_addr_d;
  logic [WORD_W-1:0] run_data_q, run_data_d;

  // decode
  logic              busy, done, armed;
  logic              wr_ok, tbl_ok, ctrl_wr, key_wr, other_wr;
  logic              start_req, op_ready, go;
  fsc_op_e           req_op;
  logic [CNT_W-1:0]  load_val;
  logic              buf_full;
  logic [ROW_W-1:0]  buf_row;
  logic [WORD_W-1:0] buf_slots [ROW_WORDS];

  assign wr_ok    = bus_wr && !busy;
  assign tbl_ok   = tbl_wr && !busy;
  assign ctrl_wr  = wr_ok && (bus_sel == SEL_CTRL);
  assign key_wr   = wr_ok && (bus_sel == SEL_KEY);
  assign other_wr = wr_ok && (bus_sel != SEL_KEY);

  assign req_op    = fsc_op_e'(bus_wdata[1:0]);
  assign start_req = ctrl_wr && bus_wdata[CTL_START];
  assign op_ready  = (req_op == OP_ERASE) || (req_op == OP_WORD) ||
                     ((req_op == OP_ROW) && buf_full);
  assign go        = start_req && armed && bus_wdata[CTL_WREN] && op_ready;

  always_comb begin
    case (req_op)
      OP_ERASE: load_val = CNT_W'(ERASE_CYCLES - 1);
      OP_ROW:   load_val = CNT_W'(ROW_CYCLES - 1);
      default:  load_val = CNT_W'(WORD_CYCLES - 1);
    endcase
  end

  always_comb begin
    wren_d     = wren_q;
    err_d      = err_q;
    op_d       = op_q;
    tgt_d      = tgt_q;
    wdat_d     = wdat_q;
    run_op_d   = run_op_q;
    run_addr_d = run_addr_q;
    run_data_d = run_data_q;
    if (ctrl_wr) begin
      wren_d = bus_wdata[CTL_WREN];
      op_d   = req_op;
      err_d  = start_req && !go;
    end
    if (wr_ok && bus_sel == SEL_TGT) begin
      tgt_d = bus_wdata[ADDR_W-1:0];
    end
    if (tbl_ok) begin
      tgt_d  = tbl_addr;
      wdat_d = tbl_wdata;
    end
    if (go) begin
      run_op_d   = req_op;
      run_addr_d = (req_op == OP_ROW) ? {buf_row, {OFS_W{1'b0}}} : tgt_q;
      run_data_d = wdat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q     <= 1'b0;
      err_q      <= 1'b0;
      op_q       <= OP_NONE;
      tgt_q      <= '0;
      wdat_q     <= '0;
      run_op_q   <= OP_NONE;
      run_addr_q <= '0;
      run_data_q <= '0;
    end else begin
      wren_q     <= wren_d;
      err_q      <= err_d;
      op_q       <= op_d;
      tgt_q      <= tgt_d;
      wdat_q     <= wdat_d;
      run_op_q   <= run_op_d;
      run_addr_q <= run_addr_d;
      run_data_q <= run_data_d;
    end
  end

  fsc_keyguard u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .other_wr (other_wr),
    .armed    (armed)
  );

  fsc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .load  (load_val),
    .busy  (busy),
    .done  (done)
  );

  fsc_rowbuf #(
    .WORD_W    (WORD_W),
    .ROW_WORDS (ROW_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (tbl_ok),
    .ld_addr   (tbl_addr),
    .ld_data   (tbl_wdata),
    .clr       (done && run_op_q == OP_ROW),
    .full_ok   (buf_full),
    .group_row (buf_row),
    .slots     (buf_slots)
  );

  fsc_array #(
    .WORD_W     (WORD_W),
    .ROW_WORDS  (ROW_WORDS),
    .PAGE_WORDS (PAGE_WORDS),
    .NUM_WORDS  (NUM_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (done),
    .upd_op    (run_op_q),
    .upd_addr  (run_addr_q),
    .word_data (run_data_q),
    .row_data  (buf_slots),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  assign stall      = busy;
  assign ctrl_rdata = {busy, wren_q, err_q, 11'b0, op_q};
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int ROW_CYCLES = 11064
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_sel,
  input logic [15:0] bus_wdata,
  input logic [15:0] ctrl_rdata,
  input logic        stall,
  input logic        armed
);
  logic [31:0] stall_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stall_run <= '0;
    else if (stall) stall_run <= stall_run + 1;
    else            stall_run <= '0;
  end

  // R2: a start without the unlock pair does nothing and flags an error
  p_unarmed_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0 && bus_wdata[15] && !stall && !armed)
      |=> (!stall && ctrl_rdata[13]));

  // R3: write-enable clear refuses the start
  p_wren_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0 && bus_wdata[15] && !bus_wdata[14] && !stall)
      |=> (!stall && ctrl_rdata[13]));

  // R4: stall only rises after a start write
  p_stall_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(bus_wr && bus_sel == 2'd0 && bus_wdata[15]));

  // R4: a row program stalls for exactly ROW_CYCLES cycles
  p_row_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && ctrl_rdata[1:0] == 2'd2) |-> (stall_run == ROW_CYCLES));

  // R5: the block is never left armed when an operation ends
  p_disarmed_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> !armed);

  // R12: control fields are frozen during an operation
  p_frozen_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ctrl_rdata[14:0]));
endmodule

bind flash_seq_ctrl fsc_checker #(.ROW_CYCLES(ROW_CYCLES)) u_fsc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_sel    (bus_sel),
  .bus_wdata  (bus_wdata),
  .ctrl_rdata (ctrl_rdata),
  .stall      (stall),
  .armed      (armed)
);

// File: tb/flash_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_seq_ctrl_tb_top;
  localparam int ROW_CYC   = 11064;
  localparam int ERASE_CYC = 16000;
  localparam int WORD_CYC  = 2000;
  localparam logic [1:0] S_CTRL = 2'd0, S_KEY = 2'd1, S_TGT = 2'd2;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_sel;
  logic [15:0] bus_wdata;
  logic [15:0] ctrl_rdata;
  logic        tbl_wr;
  logic [9:0]  tbl_addr;
  logic [23:0] tbl_wdata;
  logic        stall;
  logic [9:0]  rd_addr;
  logic [23:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  flash_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .tbl_wr(tbl_wr),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .stall(stall),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tbl_put(input logic [9:0] a, input logic [23:0] d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic peek(input logic [9:0] a, output logic [23:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic unlock();
    reg_wr(S_KEY, 16'h0055);
    reg_wr(S_KEY, 16'h00AA);
  endtask

  task automatic run_count(output int n);
    n = 0;
    while (stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [23:0] row_pat(input int i);
    return {8'h5A, 8'(i), ~8'(i)};
  endfunction

  task automatic t_reset();
    logic [23:0] d;
    chk("R1 ctrl", 32'(ctrl_rdata), 32'h0);
    chk("R1 stall", 32'(stall), 32'h0);
    peek(10'd0, d);   chk("R1 word0", 32'(d), 32'hFFFFFF);
    peek(10'd600, d); chk("R1 word600", 32'(d), 32'hFFFFFF);
    peek(10'd1023, d); chk("R1 word1023", 32'(d), 32'hFFFFFF);
  endtask

  task automatic t_word();
    int n;
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    tbl_put(10'd5, 24'h123456);
    unlock();
    reg_wr(S_CTRL, 16'hC003);
    chk("R4 busy bit", 32'(ctrl_rdata[15]), 32'h1);
    run_count(n);
    chk("R4 word time", 32'(n), 32'(WORD_CYC));
    chk("R4 start self-clear", 32'(ctrl_rdata), 32'h4003);
    peek(10'd5, d); chk("R9 word5", 32'(d), 32'h123456);
    peek(10'd4, d); chk("R9 word4 untouched", 32'(d), 32'hFFFFFF);
  endtask

  task automatic t_and_rearm();
    int n;
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    tbl_put(10'd5, 24'hFF00FF);
    unlock();
    reg_wr(S_CTRL, 16'hC003);
    run_count(n);
    peek(10'd5, d); chk("R10 and-only", 32'(d), 32'h120056);
    reg_wr(S_CTRL, 16'hC003);
    chk("R5 no rearm stall", 32'(stall), 32'h0);
    chk("R5 no rearm err", 32'(ctrl_rdata[13]), 32'h1);
  endtask

  task automatic t_unlock_breaks();
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    chk("R2 err cleared", 32'(ctrl_rdata), 32'h4003);
    reg_wr(S_KEY, 16'h0055);
    reg_wr(S_CTRL, 16'h4003);
    reg_wr(S_KEY, 16'h00AA);
    reg_wr(S_CTRL, 16'hC003);
    chk("R2 split pair stall", 32'(stall), 32'h0);
    chk("R2 split pair err", 32'(ctrl_rdata[13]), 32'h1);
    reg_wr(S_KEY, 16'h0055);
    reg_wr(S_KEY, 16'h0011);
    reg_wr(S_KEY, 16'h00AA);
    reg_wr(S_CTRL, 16'hC003);
    chk("R2 wrong key err", 32'(ctrl_rdata[13]), 32'h1);
    reg_wr(S_KEY, 16'h00AA);
    reg_wr(S_KEY, 16'h0055);
    reg_wr(S_CTRL, 16'hC003);
    chk("R2 reversed stall", 32'(stall), 32'h0);
    chk("R2 reversed err", 32'(ctrl_rdata[13]), 32'h1);
    peek(10'd5, d); chk("R2 array unchanged", 32'(d), 32'h120056);
  endtask

  task automatic t_wren();
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    tbl_put(10'd9, 24'h000000);
    unlock();
    reg_wr(S_CTRL, 16'h8003);
    chk("R3 no stall", 32'(stall), 32'h0);
    chk("R3 err", 32'(ctrl_rdata[13]), 32'h1);
    peek(10'd9, d); chk("R3 word9 untouched", 32'(d), 32'hFFFFFF);
  endtask

  task automatic t_row();
    int n;
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4002);
    for (int i = 0; i < 64; i++) tbl_put(10'(192 + i), row_pat(i));
    peek(10'd192, d); chk("R11 buffer only", 32'(d), 32'hFFFFFF);
    unlock();
    reg_wr(S_CTRL, 16'hC002);
    run_count(n);
    chk("R4 row time", 32'(n), 32'(ROW_CYC));
    peek(10'd192, d); chk("R7 row word0", 32'(d), 32'(row_pat(0)));
    peek(10'd200, d); chk("R7 row word8", 32'(d), 32'(row_pat(8)));
    peek(10'd255, d); chk("R7 row word63", 32'(d), 32'(row_pat(63)));
    peek(10'd191, d); chk("R7 below row", 32'(d), 32'hFFFFFF);
    peek(10'd256, d); chk("R7 above row", 32'(d), 32'hFFFFFF);
    unlock();
    reg_wr(S_CTRL, 16'hC002);
    chk("R7 buffer emptied", 32'({stall, ctrl_rdata[13]}), 32'h1);
  endtask

  task automatic t_row_bad();
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4002);
    for (int i = 0; i < 64; i++) if (i != 10) tbl_put(10'(64 + i), 24'h0);
    unlock();
    reg_wr(S_CTRL, 16'hC002);
    chk("R8 skipped offset", 32'({stall, ctrl_rdata[13]}), 32'h1);
    reg_wr(S_CTRL, 16'h4002);
    for (int i = 0; i < 63; i++) tbl_put(10'(64 + i), 24'h0);
    tbl_put(10'd191, 24'h0);
    unlock();
    reg_wr(S_CTRL, 16'hC002);
    chk("R8 left group", 32'({stall, ctrl_rdata[13]}), 32'h1);
    peek(10'd64, d); chk("R8 array unchanged", 32'(d), 32'hFFFFFF);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    tbl_put(10'd7, 24'h000000);
    unlock();
    reg_wr(S_CTRL, 16'hC003);
    reg_wr(S_CTRL, 16'h2000);
    tbl_put(10'd8, 24'h000000);
    reg_wr(S_KEY, 16'h0055);
    run_count(n);
    chk("R12 ctrl kept", 32'(ctrl_rdata), 32'h4003);
    peek(10'd7, d); chk("R12 word7 done", 32'(d), 32'h0);
    peek(10'd8, d); chk("R12 table ignored", 32'(d), 32'hFFFFFF);
    reg_wr(S_KEY, 16'h00AA);
    reg_wr(S_CTRL, 16'hC003);
    chk("R12 key ignored", 32'({stall, ctrl_rdata[13]}), 32'h1);
  endtask

  task automatic t_erase();
    int n;
    logic [23:0] d;
    reg_wr(S_CTRL, 16'h4003);
    tbl_put(10'd600, 24'h000000);
    unlock();
    reg_wr(S_CTRL, 16'hC003);
    run_count(n);
    peek(10'd600, d); chk("R6 setup", 32'(d), 32'h0);
    reg_wr(S_CTRL, 16'h4001);
    reg_wr(S_TGT, 16'd589);
    unlock();
    reg_wr(S_CTRL, 16'hC001);
    run_count(n);
    chk("R4 erase time", 32'(n), 32'(ERASE_CYC));
    peek(10'd600, d); chk("R6 page erased", 32'(d), 32'hFFFFFF);
    peek(10'd200, d); chk("R6 other page kept", 32'(d), 32'(row_pat(8)));
    peek(10'd5, d);   chk("R6 other page word", 32'(d), 32'h120056);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = 16'h0;
    tbl_wr = 1'b0; tbl_addr = 10'd0; tbl_wdata = 24'h0; rd_addr = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_and_rearm();
    t_unlock_breaks();
    t_wren();
    t_row();
    t_row_bad();
    t_busy_ignore();
    t_erase();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule